// File: doc/BRIEF.md
# Serial Command Decoder for a Digital Potentiometer

This block is the serial front end of a digitally controlled potentiometer. It watches a four-wire serial link: clock, active-low select, data in and a pause input. It frames each transaction into bytes and decodes the command. It then issues one-cycle request strobes to an external register bank and to an external wiper counter. Register read data, the wiper position and a write-busy flag come back in on plain inputs. On reads, the block shifts them out on a serial output that it drives only while a read response is due.

A transaction opens on a falling edge of the select line. The first byte selects the device. The second byte carries an opcode and a register pointer, and the opcode fixes the rest of the transaction. It may be a third data byte in either direction. It may end after the second byte, as the two transfers do. Or it may be an unbounded stream of step bits that ends only when select rises. Every change to a register or to the wiper is committed on the rising edge of select, and only if the sequence was complete. All pins are brought into the system clock domain through a configurable synchronizer.

Top module: `potCmdDecoder`

## Requirements
- R1: Serial input is taken on rising edges of the serial clock. Serial output changes only on falling edges. Read data leaves most significant bit first, with bit 7 valid from the first falling edge after the sixteenth rising edge.
- R2: The output enable `soOe` is low out of reset, whenever select is high, and at all times outside the data byte of a read command.
- R3: The first byte must equal `0101` in bits 7:4, `00` in bits 3:2 and the `devAddr` pins in bits 1:0. Any mismatch makes the rest of the transaction produce no strobe and no output drive.
- R4: In the second byte, bits 7:4 are the opcode, bit 3 is the register-select high bit, bit 2 the register-select low bit, and bits 1:0 the bank. The register address presented on `regAddr` is {bank[1:0], regSel[1:0]}.
- R5: Opcode 1001 returns `wiperVal`, and opcode 1011 returns `regRdData` for the addressed register, as the third byte on the serial output.
- R6: Opcode 1010 pulses `wiperLoad` once with the third byte on `wiperLoadData`. Opcode 1100 pulses `regWrEn` once with the third byte on `regWrData` at the R4 address. At most one of `wiperLoad`, `regWrEn`, `wiperStep` is high in any cycle.
- R7: Two-byte transfers need a bank field of 00; any other bank is a no-op. Opcode 1101 loads the wiper from register {00, regSel}. Opcode 1110 writes `wiperVal` into register {00, regSel}.
- R8: After opcode 0010, every further serial-clock rising edge pulses `wiperStep` once, with `wiperUp` equal to the data bit (1 = up). This continues until select rises, and step pulses are never on consecutive cycles.
- R9: Opcode 0101 returns seven zero bits followed by `writeBusy` in bit 0.
- R10: While the pause input is low, serial-clock edges are ignored and `soOe` is low. The sequence resumes at the same bit position when the pause is released.
- R11: After reset, no command takes effect until select has been seen high and then low.
- R12: Any opcode not listed above causes no strobe and no output drive.
- R13: Writes and transfers commit only after select rises. If select rises before the last bit of the final byte, nothing is committed.
- R14: While `wrProtN` is low at commit time, no `regWrEn` pulse is issued, for either a register write or a wiper-to-register transfer. Wiper loads are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSck | input | 1 | Serial clock |
| spiCsN | input | 1 | Active-low select |
| spiSi | input | 1 | Serial data in |
| spiHoldN | input | 1 | Active-low pause |
| wrProtN | input | 1 | Active-low register write protect |
| devAddr | input | 2 | Strapped device address |
| writeBusy | input | 1 | Register bank write in progress |
| wiperVal | input | 8 | Current wiper position |
| regRdData | input | 8 | Register bank read data for `regAddr` |
| spiSo | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for `spiSo` (tri-state control) |
| regAddr | output | 4 | Register address {bank, regSel} |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 8 | Register write data |
| wiperLoad | output | 1 | Wiper parallel-load strobe |
| wiperLoadData | output | 8 | Wiper load value |
| wiperStep | output | 1 | Wiper single-step strobe |
| wiperUp | output | 1 | Step direction, 1 = up |

## Verification
The hardest state to reach from the ports is a pause that lands in the middle of a byte. The block must keep its bit position while serial-clock pulses arrive that it has to ignore. The stimulus lowers the pause input partway through the data byte of a wiper write, and again in a read response. It clocks two extra pulses during each pause and then finishes the byte. The committed value and the read-back byte are both compared bit-exactly. A select that goes high in the middle of a write is also hard to reach, and is produced by ending the transaction after half of the third byte.

// File: rtl/potCmdPkg.sv
package potCmdPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  localparam logic [3:0] OP_RD_WIPER     = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER     = 4'b1010;
  localparam logic [3:0] OP_RD_REG       = 4'b1011;
  localparam logic [3:0] OP_WR_REG       = 4'b1100;
  localparam logic [3:0] OP_REG_TO_WIPER = 4'b1101;
  localparam logic [3:0] OP_WIPER_TO_REG = 4'b1110;
  localparam logic [3:0] OP_STEP         = 4'b0010;
  localparam logic [3:0] OP_STATUS       = 4'b0101;

  typedef enum logic [1:0] {SRC_WIPER, SRC_REG, SRC_STATUS} readSel_e;

  typedef enum logic [2:0] {PH_OFF, PH_ID, PH_INSTR, PH_DATA, PH_STEP, PH_SKIP} phase_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_RD, CMD_WR_WIPER, CMD_WR_REG, CMD_REG_TO_WIPER, CMD_WIPER_TO_REG
  } cmd_e;

  typedef struct packed {
    logic     shiftIn;
    logic     captureInstr;
    logic     captureData;
    logic     loadRead;
    readSel_e readSel;
    logic     shiftOut;
    logic     clearOut;
    logic     commitWiper;
    logic     commitReg;
    logic     loadFromReg;
    logic     storeFromWiper;
  } dpCtrl_t;
endpackage

// File: rtl/potSpiSync.sv
module potSpiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  input  logic holdNIn,
  output logic sckRise,
  output logic sckFall,
  output logic csFall,
  output logic csRise,
  output logic siS,
  output logic holdS
);
  localparam int CUR = STAGES - 1;
  localparam int PREV = STAGES;

  logic [STAGES:0] sckQ, csQ, siQ, holdQ;

  // select resets low so that a select already low at reset is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ  <= '0;
      csQ   <= '0;
      siQ   <= '0;
      holdQ <= '0;
    end else begin
      sckQ  <= {sckQ[STAGES-1:0], sckIn};
      csQ   <= {csQ[STAGES-1:0], csNIn};
      siQ   <= {siQ[STAGES-1:0], siIn};
      holdQ <= {holdQ[STAGES-1:0], holdNIn};
    end
  end

  assign sckRise = sckQ[CUR] & ~sckQ[PREV];
  assign sckFall = ~sckQ[CUR] & sckQ[PREV];
  assign csFall  = ~csQ[CUR] & csQ[PREV];
  assign csRise  = csQ[CUR] & ~csQ[PREV];
  assign siS     = siQ[CUR];
  assign holdS   = holdQ[CUR] & holdQ[PREV];
endmodule

// File: rtl/potCmdCtrl.sv
module potCmdCtrl
  import potCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sckRise,
  input  logic                sckFall,
  input  logic                csFall,
  input  logic                csRise,
  input  logic                siS,
  input  logic                holdS,
  input  logic [BYTE_W-1:0]   nextByte,
  input  logic [1:0]          devAddr,
  input  logic                wrProtN,
  output dpCtrl_t             dp,
  output logic                readActive,
  output logic                wiperLoad,
  output logic                regWrEn,
  output logic                wiperStep,
  output logic                wiperUp
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e          phase;
  cmd_e            cmd;
  readSel_e        readSelQ;
  logic [CNT_W-1:0] bitCnt;
  logic            complete;
  logic            loadPend;
  logic            rise, fall, counting, byteEnd;
  logic            idMatch;

  assign rise     = sckRise & holdS;
  assign fall     = sckFall & holdS;
  assign counting = phase inside {PH_ID, PH_INSTR, PH_DATA};
  assign byteEnd  = rise && counting && (bitCnt == LAST_BIT);
  assign idMatch  = (nextByte[7:4] == DEV_TYPE) && (nextByte[3:2] == 2'b00)
                    && (nextByte[1:0] == devAddr);

  always_comb begin
    dp = '0;
    dp.shiftIn        = rise && counting;
    dp.captureInstr   = byteEnd && (phase == PH_INSTR);
    dp.captureData    = byteEnd && (phase == PH_DATA) && (cmd != CMD_RD);
    dp.loadRead       = loadPend;
    dp.readSel        = readSelQ;
    dp.shiftOut       = fall && readActive;
    dp.clearOut       = csRise;
    dp.commitWiper    = csRise && complete
                        && (cmd == CMD_WR_WIPER || cmd == CMD_REG_TO_WIPER);
    dp.commitReg      = csRise && complete && wrProtN
                        && (cmd == CMD_WR_REG || cmd == CMD_WIPER_TO_REG);
    dp.loadFromReg    = (cmd == CMD_REG_TO_WIPER);
    dp.storeFromWiper = (cmd == CMD_WIPER_TO_REG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_OFF;
      cmd        <= CMD_NONE;
      readSelQ   <= SRC_WIPER;
      bitCnt     <= '0;
      complete   <= 1'b0;
      loadPend   <= 1'b0;
      readActive <= 1'b0;
    end else if (csFall) begin
      phase      <= PH_ID;
      cmd        <= CMD_NONE;
      bitCnt     <= '0;
      complete   <= 1'b0;
      loadPend   <= 1'b0;
      readActive <= 1'b0;
    end else if (csRise) begin
      phase      <= PH_OFF;
      cmd        <= CMD_NONE;
      complete   <= 1'b0;
      loadPend   <= 1'b0;
      readActive <= 1'b0;
    end else begin
      loadPend <= 1'b0;
      if (loadPend) readActive <= 1'b1;
      if (rise && counting) bitCnt <= bitCnt + 1'b1;
      if (byteEnd) begin
        unique case (phase)
          PH_ID: phase <= idMatch ? PH_INSTR : PH_SKIP;
          PH_INSTR: begin
            phase <= PH_SKIP;
            case (nextByte[7:4])
              OP_RD_WIPER: begin
                cmd <= CMD_RD; readSelQ <= SRC_WIPER; loadPend <= 1'b1; phase <= PH_DATA;
              end
              OP_RD_REG: begin
                cmd <= CMD_RD; readSelQ <= SRC_REG; loadPend <= 1'b1; phase <= PH_DATA;
              end
              OP_STATUS: begin
                cmd <= CMD_RD; readSelQ <= SRC_STATUS; loadPend <= 1'b1; phase <= PH_DATA;
              end
              OP_WR_WIPER: begin cmd <= CMD_WR_WIPER; phase <= PH_DATA; end
              OP_WR_REG:   begin cmd <= CMD_WR_REG;   phase <= PH_DATA; end
              OP_REG_TO_WIPER: if (nextByte[1:0] == 2'b00) begin
                cmd <= CMD_REG_TO_WIPER; complete <= 1'b1;
              end
              OP_WIPER_TO_REG: if (nextByte[1:0] == 2'b00) begin
                cmd <= CMD_WIPER_TO_REG; complete <= 1'b1;
              end
              OP_STEP: phase <= PH_STEP;
              default: ;
            endcase
          end
          PH_DATA: begin
            phase <= PH_SKIP;
            if (cmd != CMD_RD) complete <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperLoad <= 1'b0;
      regWrEn   <= 1'b0;
      wiperStep <= 1'b0;
      wiperUp   <= 1'b0;
    end else begin
      wiperLoad <= dp.commitWiper;
      regWrEn   <= dp.commitReg;
      wiperStep <= rise && (phase == PH_STEP) && !csRise && !csFall;
      if (rise && phase == PH_STEP) wiperUp <= siS;
    end
  end
endmodule

// File: rtl/potCmdDatapath.sv
module potCmdDatapath
  import potCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic              siS,
  input  logic [BYTE_W-1:0] wiperVal,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic              writeBusy,
  output logic [BYTE_W-1:0] nextByte,
  output logic [3:0]        regAddr,
  output logic              soBit,
  output logic [BYTE_W-1:0] wiperLoadData,
  output logic [BYTE_W-1:0] regWrData
);
  logic [BYTE_W-1:0] inShift, dataReg, outShift, readData;
  logic [3:0]        ptrReg;

  assign nextByte = {inShift[BYTE_W-2:0], siS};
  assign regAddr  = {ptrReg[1:0], ptrReg[3:2]};

  always_comb begin
    unique case (dp.readSel)
      SRC_REG:    readData = regRdData;
      SRC_STATUS: readData = {{(BYTE_W-1){1'b0}}, writeBusy};
      default:    readData = wiperVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift       <= '0;
      ptrReg        <= '0;
      dataReg       <= '0;
      outShift      <= '0;
      soBit         <= 1'b0;
      wiperLoadData <= '0;
      regWrData     <= '0;
    end else begin
      if (dp.shiftIn)      inShift <= nextByte;
      if (dp.captureInstr) ptrReg  <= nextByte[3:0];
      if (dp.captureData)  dataReg <= nextByte;
      if (dp.clearOut) begin
        outShift <= '0;
        soBit    <= 1'b0;
      end else if (dp.loadRead) begin
        outShift <= readData;
      end else if (dp.shiftOut) begin
        soBit    <= outShift[BYTE_W-1];
        outShift <= {outShift[BYTE_W-2:0], 1'b0};
      end
      if (dp.commitWiper) wiperLoadData <= dp.loadFromReg ? regRdData : dataReg;
      if (dp.commitReg)   regWrData     <= dp.storeFromWiper ? wiperVal : dataReg;
    end
  end
endmodule

// File: rtl/potCmdDecoder.sv
module potCmdDecoder
  import potCmdPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiSi,
  input  logic              spiHoldN,
  input  logic              wrProtN,
  input  logic [1:0]        devAddr,
  input  logic              writeBusy,
  input  logic [BYTE_W-1:0] wiperVal,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              spiSo,
  output logic              soOe,
  output logic [3:0]        regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              wiperLoad,
  output logic [BYTE_W-1:0] wiperLoadData,
  output logic              wiperStep,
  output logic              wiperUp
);
  logic sckRise, sckFall, csFall, csRise, siS, holdS;
  logic readActive;
  logic [BYTE_W-1:0] nextByte;
  dpCtrl_t dp;

  potSpiSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiSi),
    .holdNIn(spiHoldN), .sckRise(sckRise), .sckFall(sckFall), .csFall(csFall),
    .csRise(csRise), .siS(siS), .holdS(holdS)
  );

  potCmdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csFall(csFall), .csRise(csRise), .siS(siS), .holdS(holdS),
    .nextByte(nextByte), .devAddr(devAddr), .wrProtN(wrProtN), .dp(dp),
    .readActive(readActive), .wiperLoad(wiperLoad), .regWrEn(regWrEn),
    .wiperStep(wiperStep), .wiperUp(wiperUp)
  );

  potCmdDatapath u_dp (
    .clk(clk), .rstN(rstN), .dp(dp), .siS(siS), .wiperVal(wiperVal),
    .regRdData(regRdData), .writeBusy(writeBusy), .nextByte(nextByte),
    .regAddr(regAddr), .soBit(spiSo), .wiperLoadData(wiperLoadData),
    .regWrData(regWrData)
  );

  // release the line at once from the raw pins, without waiting for synchronizers
  assign soOe = readActive & ~spiCsN & spiHoldN;
endmodule

// File: rtl/potCmdChecker.sv
module potCmdChecker (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic wrProtN,
  input logic wiperLoad,
  input logic regWrEn,
  input logic wiperStep
);
  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wiperLoad, regWrEn, wiperStep}));

  // R14
  write_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(wrProtN));

  // R13
  commit_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wiperLoad || regWrEn) |-> $past(spiCsN));

  // R8
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    wiperStep |=> !wiperStep);
endmodule

bind potCmdDecoder potCmdChecker i_potCmdChecker (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .wrProtN(wrProtN),
  .wiperLoad(wiperLoad), .regWrEn(regWrEn), .wiperStep(wiperStep)
);

// File: tb/test_potCmdDecoder.sv
module test_potCmdDecoder;
  localparam int HALF = 8;
  localparam logic [1:0] DEV = 2'b10;
  localparam logic [7:0] ID_OK = {4'b0101, 2'b00, DEV};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b0, spiSi = 1'b0, spiHoldN = 1'b1;
  logic wrProtN = 1'b1, writeBusy = 1'b0;
  logic [1:0] devAddr = DEV;
  logic [7:0] wiperVal, regRdData, regWrData, wiperLoadData;
  logic [3:0] regAddr;
  logic spiSo, soOe, regWrEn, wiperLoad, wiperStep, wiperUp;

  logic [7:0] modelMem [16];
  logic [7:0] modelWiper = 8'h00;
  assign wiperVal  = modelWiper;
  assign regRdData = modelMem[regAddr];

  always #4 clk = ~clk;

  potCmdDecoder i_potCmdDecoder (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiHoldN(spiHoldN), .wrProtN(wrProtN), .devAddr(devAddr),
    .writeBusy(writeBusy), .wiperVal(wiperVal), .regRdData(regRdData),
    .spiSo(spiSo), .soOe(soOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .wiperLoad(wiperLoad), .wiperLoadData(wiperLoadData),
    .wiperStep(wiperStep), .wiperUp(wiperUp)
  );

  typedef struct { int kind; int addr; int data; string req; } evt_t;
  evt_t expQ[$];
  int checks = 0, fails = 0, eventCount = 0;
  string curReq = "R6";
  logic oeSeen = 1'b0;
  logic [7:0] rxShift = 8'h00;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expectEvt(input int kind, input int addr, input int data, input string req);
    evt_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.req = req;
    expQ.push_back(e);
  endtask

  // scoreboard monitor: kind 0 = wiper load, 1 = register write, 2 = step
  always @(negedge clk) begin
    if (rstN && (wiperLoad || regWrEn || wiperStep)) begin
      evt_t e;
      int k, a, d;
      eventCount++;
      k = wiperLoad ? 0 : (regWrEn ? 1 : 2);
      a = regWrEn ? int'(regAddr) : 0;
      d = wiperLoad ? int'(wiperLoadData) : (regWrEn ? int'(regWrData) : int'(wiperUp));
      if (expQ.size() == 0) begin
        check({curReq, " unexpected strobe kind"}, k, -1);
      end else begin
        e = expQ.pop_front();
        check({e.req, " strobe kind"}, k, e.kind);
        check({e.req, " strobe addr"}, a, e.addr);
        check({e.req, " strobe data"}, d, e.data);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBit(input logic b);
    spiSi = b;
    waitClk(HALF);
    spiSck = 1'b1;
    rxShift = {rxShift[6:0], spiSo};
    oeSeen = oeSeen | soOe;
    waitClk(HALF);
    spiSck = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spiBit(b[i]);
  endtask

  task automatic csStart();
    oeSeen = 1'b0;
    waitClk(4);
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csEnd();
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(12);
  endtask

  task automatic cmd3(input logic [7:0] id, input logic [7:0] instr, input logic [7:0] data);
    csStart(); sendByte(id); sendByte(instr); sendByte(data); csEnd();
  endtask

  task automatic cmd2(input logic [7:0] id, input logic [7:0] instr);
    csStart(); sendByte(id); sendByte(instr); csEnd();
  endtask

  task automatic holdPause(input string req);
    waitClk(4);
    spiHoldN = 1'b0;
    waitClk(6);
    check({req, " soOe during pause"}, int'(soOe), 0);
    spiSi = 1'b1;
    for (int p = 0; p < 2; p++) begin
      spiSck = 1'b1; waitClk(HALF);
      check({req, " soOe during pause pulse"}, int'(soOe), 0);
      spiSck = 1'b0; waitClk(HALF);
    end
    waitClk(4);
    spiHoldN = 1'b1;
    waitClk(6);
  endtask

  task automatic drained(input string req);
    check({req, " pending expected strobes"}, expQ.size(), 0);
  endtask

  initial begin
    int e0;
    for (int i = 0; i < 16; i++) modelMem[i] = 8'h10 + 8'(i);
    waitClk(10);
    rstN = 1'b1;
    waitClk(4);
    check("R2 soOe after reset", int'(soOe), 0);

    // R11: select low since reset, no falling edge seen
    curReq = "R11"; e0 = eventCount; oeSeen = 1'b0;
    sendByte(ID_OK); sendByte(8'hA0); sendByte(8'h77);
    spiCsN = 1'b1; waitClk(20);
    check("R11 no strobe before first select fall", eventCount - e0, 0);
    check("R11 no drive before first select fall", int'(oeSeen), 0);

    // R6 wiper write
    curReq = "R6";
    expectEvt(0, 0, 8'h5A, "R6");
    cmd3(ID_OK, 8'hA0, 8'h5A); modelWiper = 8'h5A;
    drained("R6");

    // R1 R5 wiper read
    curReq = "R5";
    cmd3(ID_OK, 8'h90, 8'h00);
    check("R1 R5 wiper read byte", int'(rxShift), 8'h5A);
    check("R2 soOe with select high", int'(soOe), 0);

    // R4 R6 register write, bank 2 register 1 -> address 9
    curReq = "R4";
    expectEvt(1, 9, 8'h3C, "R4");
    cmd3(ID_OK, 8'hC6, 8'h3C); modelMem[9] = 8'h3C;
    drained("R4");
    curReq = "R5";
    cmd3(ID_OK, 8'hB6, 8'h00);
    check("R5 register read byte", int'(rxShift), 8'h3C);

    // R14 write protect
    curReq = "R14"; e0 = eventCount;
    wrProtN = 1'b0; cmd3(ID_OK, 8'hC6, 8'hEE); wrProtN = 1'b1;
    check("R14 protected write no strobe", eventCount - e0, 0);

    // R3 address and type mismatches
    curReq = "R3"; e0 = eventCount;
    cmd3({4'b0101, 2'b00, 2'b01}, 8'hA0, 8'h99);
    cmd3({4'b0110, 2'b00, DEV}, 8'h90, 8'h00);
    check("R3 mismatch no drive", int'(oeSeen), 0);
    cmd3({4'b0101, 2'b01, DEV}, 8'hA0, 8'h98);
    check("R3 mismatch no strobe", eventCount - e0, 0);

    // R7 transfers
    curReq = "R7";
    expectEvt(0, 0, 8'h13, "R7");
    cmd2(ID_OK, 8'hDC); modelWiper = 8'h13;
    drained("R7 reg to wiper");
    expectEvt(1, 2, 8'h13, "R7");
    cmd2(ID_OK, 8'hE8); modelMem[2] = 8'h13;
    drained("R7 wiper to reg");
    e0 = eventCount;
    cmd2(ID_OK, 8'hE9);
    cmd2(ID_OK, 8'hDD);
    check("R7 nonzero bank no strobe", eventCount - e0, 0);
    curReq = "R14"; e0 = eventCount;
    wrProtN = 1'b0; cmd2(ID_OK, 8'hE8); wrProtN = 1'b1;
    check("R14 protected transfer no strobe", eventCount - e0, 0);

    // R12 unknown opcodes
    curReq = "R12"; e0 = eventCount;
    cmd3(ID_OK, 8'h00, 8'h00);
    check("R12 unknown opcode no drive", int'(oeSeen), 0);
    cmd3(ID_OK, 8'hF0, 8'h55);
    check("R12 unknown opcode no strobe", eventCount - e0, 0);

    // R9 status
    curReq = "R9";
    writeBusy = 1'b1; cmd3(ID_OK, 8'h51, 8'h00);
    check("R9 status busy", int'(rxShift), 8'h01);
    writeBusy = 1'b0; cmd3(ID_OK, 8'h51, 8'h00);
    check("R9 status idle", int'(rxShift), 8'h00);

    // R8 step stream
    curReq = "R8";
    expectEvt(2, 0, 1, "R8"); expectEvt(2, 0, 1, "R8"); expectEvt(2, 0, 0, "R8");
    expectEvt(2, 0, 1, "R8"); expectEvt(2, 0, 0, "R8");
    csStart(); sendByte(ID_OK); sendByte(8'h20);
    spiBit(1'b1); spiBit(1'b1); spiBit(1'b0); spiBit(1'b1); spiBit(1'b0);
    csEnd();
    drained("R8");

    // R13 truncated write
    curReq = "R13"; e0 = eventCount;
    csStart(); sendByte(ID_OK); sendByte(8'hC6);
    spiBit(1'b1); spiBit(1'b0); spiBit(1'b1); spiBit(1'b0);
    csEnd();
    check("R13 truncated write no strobe", eventCount - e0, 0);
    cmd3(ID_OK, 8'hB6, 8'h00);
    check("R13 register unchanged", int'(rxShift), 8'h3C);

    // R10 pause inside a write and inside a read
    curReq = "R10";
    expectEvt(0, 0, 8'hA5, "R10");
    csStart(); sendByte(ID_OK); sendByte(8'hA0);
    spiBit(1'b1); spiBit(1'b0); spiBit(1'b1); spiBit(1'b0);
    holdPause("R10");
    spiBit(1'b0); spiBit(1'b1); spiBit(1'b0); spiBit(1'b1);
    csEnd(); modelWiper = 8'hA5;
    drained("R10 paused write");
    csStart(); sendByte(ID_OK); sendByte(8'h90);
    spiBit(1'b0); spiBit(1'b0); spiBit(1'b0);
    holdPause("R10");
    for (int j = 0; j < 5; j++) spiBit(1'b0);
    csEnd();
    check("R10 paused read byte", int'(rxShift), 8'hA5);

    waitClk(10);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule